// File: doc/BRIEF.md
# Joinable Two-Channel Pulse Width Modulator

This block drives two output pins with pulse-width-modulated waveforms. Each channel has an up-counter, a period byte and a duty byte, and it runs from one of two prescaled clocks. A control bit can join the two 8-bit channels into a single 16-bit modulator for finer resolution. In joined mode, channel 0 supplies the upper byte of the period and duty values and channel 1 supplies the lower byte. The joined waveform appears only on pin 0, and pin 1 carries a general-purpose data input instead.

Software programs the block through a small synchronous register port and can read back every register at any time. New period and duty values are double-buffered: they wait in shadow registers until the counter wraps, so a waveform never shows a mix of old and new settings. A change of the join bit takes effect on the next tick of channel 1's clock. At that tick both counters restart from zero.

Top module: `pwm_pair`

## Requirements
- R1: In split mode (control bit 7 = 0), each channel counts 0,1,…,P on its own clock ticks and then wraps, so one cycle lasts P+1 ticks. Its pin is high while the count is below its duty D and low otherwise. Channel 0 uses address 2 (period) and address 4 (duty). Channel 1 uses address 3 (period) and address 5 (duty).
- R2: A duty of 0 keeps the pin low at all times. A nonzero duty that is greater than or equal to the period keeps the pin high at all times.
- R3: In joined mode (control bit 7 = 1), one 16-bit counter produces the waveform on pin 0. The 16-bit period is {address 2, address 3} and the 16-bit duty is {address 4, address 5}, with address 2 and address 4 as the upper bytes. The R1 and R2 rules apply to these 16-bit values.
- R4: In joined mode, pin 1 follows the `gpio1_d` input. In split mode, pin 1 carries channel 1's waveform and ignores `gpio1_d`.
- R5: In joined mode, the 16-bit counter advances on the clock selected for channel 1 (address 1 bit 1). The clock selected for channel 0 has no effect.
- R6: Control bits 5:3 hold exponent NA and bits 2:0 hold exponent NB. Clock A ticks once every 2^NA input cycles and clock B once every 2^NB input cycles. In address 1, bit 0 selects channel 0's clock and bit 1 selects channel 1's clock (0 = A, 1 = B).
- R7: Reset clears every register to zero, so both pins are low and the block starts in split mode with divide-by-1 clocks. Reads return the stored fields at any time. Unused bits (control bit 6 and address 1 bits 7:2) read as 0, and addresses 6 and 7 read as 0.
- R8: A written period or duty value takes effect only when the counter using it wraps. In joined mode, all four bytes are taken over together at the 16-bit wrap.
- R9: When the join bit is changed, the block switches mode at the next tick of channel 1's selected clock. At that tick both counters restart from 0 and all period and duty values are reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | CW | Write data |
| reg_rdata | output | CW | Read data for `reg_addr` (combinational) |
| gpio1_d | input | 1 | Data driven onto pin 1 in joined mode |
| pin0 | output | 1 | Channel 0 or joined waveform |
| pin1 | output | 1 | Channel 1 waveform, or general-purpose data in joined mode |

## Verification
The bench targets the places where a join-capable modulator usually goes wrong, and in each case it measures the pin waveform itself.

- **Byte order:** a 16-bit period whose two bytes differ checks which byte is upper. Swapped bytes would change both the pulse length and the cycle length.
- **Joined clock source:** it runs channels 0 and 1 on different dividers while joined and counts rising edges. A design that took its clock from channel 0 would show twice as many edges.
- **Buffered duty:** it rewrites the duty in the middle of a cycle. A design without buffering would raise the pin before the wrap.
- **Mode switch:** it switches modes while channel 1's count sits above its duty. A design that did not clear the counters would start the joined waveform low instead of high.
- **Duty limits:** zero and saturated duty values must give flat levels.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
   localparam int unsigned ADDR_W = 3;
   localparam int unsigned NCLK   = 2;

   typedef enum logic [ADDR_W-1:0] {
      RA_CTRL  = 3'd0,
      RA_CSEL  = 3'd1,
      RA_PER0  = 3'd2,
      RA_PER1  = 3'd3,
      RA_DUTY0 = 3'd4,
      RA_DUTY1 = 3'd5
   } reg_addr_e;
endpackage

// File: rtl/pwm_prescale.sv
// One free-running counter shared by all clock taps; each tap fires once
// every 2^exp input cycles.
module pwm_prescale #(
   parameter int unsigned PSW  = 3,
   parameter int unsigned NTAP = 2
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [NTAP-1:0][PSW-1:0]  exps,
   output logic [NTAP-1:0]           ticks
);
   localparam int unsigned DW = (1 << PSW) - 1;

   if (PSW < 1) begin : g_bad_psw
      $error("pwm_prescale: PSW must be at least 1");
   end

   logic [DW-1:0] free_cnt;

   always_ff @(posedge clk) begin
      if (rst) free_cnt <= '0;
      else     free_cnt <= free_cnt + 1'b1;
   end

   for (genvar t = 0; t < NTAP; t++) begin : g_tap
      logic [DW:0]   wide_mask;
      logic [DW-1:0] low_mask;
      always_comb begin
         wide_mask = ((DW+1)'(1) << exps[t]) - 1'b1;
         low_mask  = wide_mask[DW-1:0];
      end
      assign ticks[t] = &(free_cnt | ~low_mask);

      // R6: with a nonzero exponent held steady, ticks are never back to back
      p_tick_gap_r6: assert property (@(posedge clk) disable iff (rst)
         (exps[t] != '0 && $stable(exps[t]) && ticks[t]) |=> !ticks[t]);
   end
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
   import pwm_pair_pkg::*;
#(
   parameter int unsigned CW  = 8,
   parameter int unsigned PSW = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CW-1:0]     wdata,
   output logic [CW-1:0]     rdata,
   output logic              fuse_req,
   output logic [PSW-1:0]    exp_a,
   output logic [PSW-1:0]    exp_b,
   output logic [1:0]        clk_sel,
   output logic [CW-1:0]     per0,
   output logic [CW-1:0]     per1,
   output logic [CW-1:0]     duty0,
   output logic [CW-1:0]     duty1
);
   localparam int unsigned FUSE_BIT = CW - 1;
   localparam int unsigned A_LO     = PSW;
   localparam int unsigned B_LO     = 0;

   if (CW < 2*PSW + 2) begin : g_bad_fit
      $error("pwm_regs: control fields do not fit in CW bits");
   end

   logic [CW-1:0] ctrl_view;

   always_ff @(posedge clk) begin
      if (rst) begin
         fuse_req <= 1'b0;
         exp_a    <= '0;
         exp_b    <= '0;
         clk_sel  <= '0;
         per0     <= '0;
         per1     <= '0;
         duty0    <= '0;
         duty1    <= '0;
      end else if (we) begin
         case (addr)
            RA_CTRL: begin
               fuse_req <= wdata[FUSE_BIT];
               exp_a    <= wdata[A_LO +: PSW];
               exp_b    <= wdata[B_LO +: PSW];
            end
            RA_CSEL:  clk_sel <= wdata[1:0];
            RA_PER0:  per0    <= wdata;
            RA_PER1:  per1    <= wdata;
            RA_DUTY0: duty0   <= wdata;
            RA_DUTY1: duty1   <= wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      ctrl_view              = '0;
      ctrl_view[FUSE_BIT]    = fuse_req;
      ctrl_view[A_LO +: PSW] = exp_a;
      ctrl_view[B_LO +: PSW] = exp_b;
   end

   always_comb begin
      case (addr)
         RA_CTRL:  rdata = ctrl_view;
         RA_CSEL:  rdata = {{(CW-2){1'b0}}, clk_sel};
         RA_PER0:  rdata = per0;
         RA_PER1:  rdata = per1;
         RA_DUTY0: rdata = duty0;
         RA_DUTY1: rdata = duty1;
         default:  rdata = '0;
      endcase
   end

   // R7: the cycle after reset every field is zero
   p_reset_clear_r7: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!fuse_req && exp_a == '0 && exp_b == '0 && clk_sel == '0
                      && per0 == '0 && per1 == '0 && duty0 == '0 && duty1 == '0));
endmodule

// File: rtl/pwm_cnt_pair.sv
// Two byte counters with their active (buffered) period/duty values; in
// joined mode they chain into one 16-bit counter clocked by tick1.
module pwm_cnt_pair #(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          tick0,
   input  logic          tick1,
   input  logic          fuse_req,
   input  logic [CW-1:0] sh_per0,
   input  logic [CW-1:0] sh_per1,
   input  logic [CW-1:0] sh_duty0,
   input  logic [CW-1:0] sh_duty1,
   output logic          mode,
   output logic [CW-1:0] cnt0,
   output logic [CW-1:0] cnt1,
   output logic [CW-1:0] ap0,
   output logic [CW-1:0] ap1,
   output logic [CW-1:0] ad0,
   output logic [CW-1:0] ad1
);
   localparam int unsigned JW = 2 * CW;

   logic [JW-1:0] cnt_j, per_j;
   logic          do_switch, wrap0, wrap1, wrap_j;

   assign cnt_j     = {cnt0, cnt1};
   assign per_j     = {ap0, ap1};
   assign do_switch = (fuse_req != mode) && tick1;
   assign wrap0     = (cnt0 == ap0);
   assign wrap1     = (cnt1 == ap1);
   assign wrap_j    = (cnt_j == per_j);

   always_ff @(posedge clk) begin
      if (rst) begin
         mode <= 1'b0;
         cnt0 <= '0;
         cnt1 <= '0;
         ap0  <= '0;
         ap1  <= '0;
         ad0  <= '0;
         ad1  <= '0;
      end else if (do_switch) begin
         mode <= fuse_req;
         cnt0 <= '0;
         cnt1 <= '0;
         ap0  <= sh_per0;
         ap1  <= sh_per1;
         ad0  <= sh_duty0;
         ad1  <= sh_duty1;
      end else if (mode) begin
         if (tick1) begin
            if (wrap_j) begin
               cnt0 <= '0;
               cnt1 <= '0;
               ap0  <= sh_per0;
               ap1  <= sh_per1;
               ad0  <= sh_duty0;
               ad1  <= sh_duty1;
            end else begin
               {cnt0, cnt1} <= cnt_j + 1'b1;
            end
         end
      end else begin
         if (tick0) begin
            if (wrap0) begin
               cnt0 <= '0;
               ap0  <= sh_per0;
               ad0  <= sh_duty0;
            end else begin
               cnt0 <= cnt0 + 1'b1;
            end
         end
         if (tick1) begin
            if (wrap1) begin
               cnt1 <= '0;
               ap1  <= sh_per1;
               ad1  <= sh_duty1;
            end else begin
               cnt1 <= cnt1 + 1'b1;
            end
         end
      end
   end

   // R1: split counters never pass their active period
   p_split_bound_r1: assert property (@(posedge clk) disable iff (rst)
      !mode |-> (cnt0 <= ap0 && cnt1 <= ap1));
   // R3: joined counter never passes the 16-bit period
   p_joined_bound_r3: assert property (@(posedge clk) disable iff (rst)
      mode |-> (cnt_j <= per_j));
   // R9: a mode change always leaves both counters at zero
   p_switch_clear_r9: assert property (@(posedge clk) disable iff (rst)
      (mode != $past(mode)) |-> (cnt0 == '0 && cnt1 == '0));
   // R8: joined period only changes together with a restart at zero
   p_pair_load_r8: assert property (@(posedge clk) disable iff (rst)
      (mode && $past(mode) && per_j != $past(per_j)) |-> (cnt_j == '0));
endmodule

// File: rtl/pwm_cmp.sv
module pwm_cmp #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] per,
   input  logic [W-1:0] duty,
   output logic         wave
);
   assign wave = (duty != '0) && ((duty >= per) || (cnt < duty));
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
   import pwm_pair_pkg::*;
#(
   parameter int unsigned CW  = 8,
   parameter int unsigned PSW = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [CW-1:0]     reg_wdata,
   output logic [CW-1:0]     reg_rdata,
   input  logic              gpio1_d,
   output logic              pin0,
   output logic              pin1
);
   localparam int unsigned JW = 2 * CW;

   if (CW < 2) begin : g_bad_cw
      $error("pwm_pair: CW must be at least 2");
   end

   logic                      fuse_req, mode;
   logic [PSW-1:0]            exp_a, exp_b;
   logic [1:0]                clk_sel;
   logic [CW-1:0]             per0, per1, duty0, duty1;
   logic [CW-1:0]             cnt0, cnt1, ap0, ap1, ad0, ad1;
   logic [NCLK-1:0][PSW-1:0]  exps;
   logic [NCLK-1:0]           clk_ticks;
   logic [1:0]                ch_tick;
   logic [1:0]                ch_wave;
   logic                      joined_wave;

   pwm_regs #(.CW(CW), .PSW(PSW)) u_regs (
      .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .fuse_req(fuse_req), .exp_a(exp_a), .exp_b(exp_b),
      .clk_sel(clk_sel), .per0(per0), .per1(per1), .duty0(duty0), .duty1(duty1)
   );

   assign exps[0] = exp_a;
   assign exps[1] = exp_b;

   pwm_prescale #(.PSW(PSW), .NTAP(NCLK)) u_psc (
      .clk(clk), .rst(rst), .exps(exps), .ticks(clk_ticks)
   );

   for (genvar c = 0; c < 2; c++) begin : g_sel
      assign ch_tick[c] = clk_sel[c] ? clk_ticks[1] : clk_ticks[0];
   end

   pwm_cnt_pair #(.CW(CW)) u_cnt (
      .clk(clk), .rst(rst), .tick0(ch_tick[0]), .tick1(ch_tick[1]),
      .fuse_req(fuse_req), .sh_per0(per0), .sh_per1(per1),
      .sh_duty0(duty0), .sh_duty1(duty1), .mode(mode),
      .cnt0(cnt0), .cnt1(cnt1), .ap0(ap0), .ap1(ap1), .ad0(ad0), .ad1(ad1)
   );

   pwm_cmp #(.W(CW)) u_cmp0 (.cnt(cnt0), .per(ap0), .duty(ad0), .wave(ch_wave[0]));
   pwm_cmp #(.W(CW)) u_cmp1 (.cnt(cnt1), .per(ap1), .duty(ad1), .wave(ch_wave[1]));
   pwm_cmp #(.W(JW)) u_cmpj (
      .cnt({cnt0, cnt1}), .per({ap0, ap1}), .duty({ad0, ad1}), .wave(joined_wave)
   );

   assign pin0 = mode ? joined_wave : ch_wave[0];
   assign pin1 = mode ? gpio1_d     : ch_wave[1];

   // R2: zero duty in split mode keeps pin 0 low
   p_zero_duty_low_r2: assert property (@(posedge clk) disable iff (rst)
      (!mode && ad0 == '0) |-> !pin0);
   // R2: saturated duty in split mode keeps pin 0 high
   p_full_duty_high_r2: assert property (@(posedge clk) disable iff (rst)
      (!mode && ad0 != '0 && ad0 >= ap0) |-> pin0);
   // R4: while joined, pin 1 only moves when the data input moves
   p_gpio_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (mode && $past(mode) && $stable(gpio1_d)) |-> $stable(pin1));
endmodule

// File: tb/sim_pwm_pair.sv
`timescale 1ns/1ps
module sim_pwm_pair;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       we = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       gpio1_d = 1'b0;
   logic       pin0, pin1;
   int         n_tests = 0;
   int         n_fail  = 0;
   bit         done    = 1'b0;

   always #5 clk = ~clk;

   pwm_pair #(.CW(8), .PSW(3)) u0 (
      .clk(clk), .rst(rst), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
      .reg_rdata(rdata), .gpio1_d(gpio1_d), .pin0(pin0), .pin1(pin1)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic measure(input int which, input int n, output int hi, output int rises);
      logic prev, s;
      hi = 0; rises = 0;
      prev = which ? pin1 : pin0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         s = which ? pin1 : pin0;
         hi += s;
         if (s && !prev) rises++;
         prev = s;
      end
   endtask

   task automatic wait_edge(input int which, input bit rising);
      logic prev, s;
      prev = which ? pin1 : pin0;
      forever begin
         @(negedge clk);
         s = which ? pin1 : pin0;
         if (rising ? (s && !prev) : (!s && prev)) break;
         prev = s;
      end
   endtask

   task automatic t_reset();
      logic [7:0] d;
      do_reset();
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), d);
         chk(d == 8'h00, "R7 reset readback", d, 0);
      end
      chk(pin0 == 1'b0 && pin1 == 1'b0, "R7 pins low after reset", {pin0, pin1}, 0);
      wr(3'd0, 8'hFF); rd(3'd0, d);
      chk(d == 8'hBF, "R7 control readback", d, 8'hBF);
      wr(3'd1, 8'hFF); rd(3'd1, d);
      chk(d == 8'h03, "R7 select readback", d, 3);
      wr(3'd4, 8'h5A); rd(3'd4, d);
      chk(d == 8'h5A, "R7 duty readback", d, 8'h5A);
   endtask

   task automatic t_split();
      int hi, rs;
      do_reset();
      gpio1_d = 1'b1;
      wr(3'd2, 8'd9); wr(3'd4, 8'd3);
      wr(3'd3, 8'd4); wr(3'd5, 8'd2);
      repeat (20) @(negedge clk);
      measure(0, 100, hi, rs);
      chk(hi == 30, "R1 ch0 high cycles", hi, 30);
      chk(rs == 10, "R1 ch0 cycle count", rs, 10);
      measure(1, 100, hi, rs);
      chk(hi == 40, "R1 R4 ch1 high cycles", hi, 40);
      chk(rs == 20, "R1 ch1 cycle count", rs, 20);
      gpio1_d = 1'b0;
   endtask

   task automatic t_edges();
      int hi, rs;
      do_reset();
      wr(3'd2, 8'd5); wr(3'd4, 8'd0);
      wr(3'd3, 8'd5); wr(3'd5, 8'd200);
      repeat (20) @(negedge clk);
      measure(0, 60, hi, rs);
      chk(hi == 0, "R2 zero duty low", hi, 0);
      measure(1, 60, hi, rs);
      chk(hi == 60, "R2 duty above period high", hi, 60);
      wr(3'd4, 8'd5);
      repeat (20) @(negedge clk);
      measure(0, 60, hi, rs);
      chk(hi == 60, "R2 duty equal period high", hi, 60);
   endtask

   task automatic t_prescale();
      int hi, rs;
      do_reset();
      wr(3'd2, 8'd3); wr(3'd4, 8'd1);
      wr(3'd3, 8'd3); wr(3'd5, 8'd2);
      wr(3'd1, 8'h02);
      wr(3'd0, 8'h11);
      repeat (60) @(negedge clk);
      measure(0, 160, hi, rs);
      chk(rs == 10, "R6 clock A div4 cycles", rs, 10);
      chk(hi == 40, "R6 clock A div4 high", hi, 40);
      measure(1, 160, hi, rs);
      chk(rs == 20, "R6 clock B div2 cycles", rs, 20);
      chk(hi == 80, "R6 clock B div2 high", hi, 80);
   endtask

   task automatic t_joined();
      int hi, rs;
      do_reset();
      wr(3'd2, 8'h01); wr(3'd3, 8'h03);
      wr(3'd4, 8'h00); wr(3'd5, 8'h40);
      wr(3'd0, 8'h80);
      repeat (300) @(negedge clk);
      measure(0, 520, hi, rs);
      chk(hi == 128, "R3 joined high cycles", hi, 128);
      chk(rs == 2, "R3 joined cycle count", rs, 2);
      gpio1_d = 1'b1; @(negedge clk);
      chk(pin1 == 1'b1, "R4 pin1 follows data high", pin1, 1);
      gpio1_d = 1'b0; @(negedge clk);
      chk(pin1 == 1'b0, "R4 pin1 follows data low", pin1, 0);
   endtask

   task automatic t_joined_clk();
      int hi, rs;
      do_reset();
      wr(3'd2, 8'h00); wr(3'd3, 8'd9);
      wr(3'd4, 8'h00); wr(3'd5, 8'd3);
      wr(3'd1, 8'h02);
      wr(3'd0, 8'h81);
      repeat (60) @(negedge clk);
      measure(0, 200, hi, rs);
      chk(rs == 10, "R5 joined uses ch1 clock", rs, 10);
      chk(hi == 60, "R5 joined high cycles", hi, 60);
   endtask

   task automatic t_buffer();
      int hi, rs;
      do_reset();
      wr(3'd2, 8'd49); wr(3'd4, 8'd10);
      repeat (60) @(negedge clk);
      wait_edge(0, 1'b1);
      repeat (20) @(negedge clk);
      wr(3'd4, 8'd40);
      repeat (10) @(negedge clk);
      chk(pin0 == 1'b0, "R8 duty held until wrap", pin0, 0);
      wait_edge(0, 1'b1);
      measure(0, 100, hi, rs);
      chk(hi == 80, "R8 new duty after wrap", hi, 80);
   endtask

   task automatic t_switch();
      do_reset();
      wr(3'd2, 8'd0); wr(3'd4, 8'd0);
      wr(3'd3, 8'd200); wr(3'd5, 8'd100);
      repeat (250) @(negedge clk);
      wait_edge(1, 1'b0);
      wr(3'd0, 8'h80);
      repeat (2) @(negedge clk);
      chk(pin0 == 1'b1, "R9 restart high after join", pin0, 1);
      repeat (88) @(negedge clk);
      chk(pin0 == 1'b1, "R9 still high mid pulse", pin0, 1);
      repeat (20) @(negedge clk);
      chk(pin0 == 1'b0, "R9 low after joined duty", pin0, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_split();
      t_edges();
      t_prescale();
      t_joined();
      t_joined_clk();
      t_buffer();
      t_switch();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule